// File: doc/BRIEF.md
# DMA Transfer Address Generator

This block computes the physical memory address and the transfer progress for whichever DMA channel is currently active. A 31-bit byte address is built from three parts: a 7-bit upper page, an 8-bit lower page and the 16-bit current address of the channel. The block stores both page values for four channels. Firmware loads them through a small page-register port that uses a fixed and sparse offset map.

Each channel has its own transferred-count register. A transfer strobe moves the count of the selected channel forward by one unit. A unit is one byte in byte mode or two bytes in word mode. The address for the next unit is derived from the count. In the upward direction it is the current address plus the count. In the downward direction it sits one unit below the current address minus the count. When the count reaches the programmed length, the block sends out a one-cycle terminal-count pulse tagged with the channel number. A channel set for autoinitialisation then returns its count to zero on its own. A channel without autoinitialisation holds at the end until it is restarted. Bus handshakes and data movement are handled elsewhere.

Top module: `dma_addr_gen`

## Requirements
- R1: After reset every page register reads 0, every channel's transferred count is 0 and the terminal-count pulse is low.
- R2: Page-register offsets select channels as follows: offset 7 is channel 0, offset 3 is channel 1, offset 1 is channel 2 and offset 2 is channel 3. `pg_rd_hi`=0 selects the lower page and 1 selects the upper page. The upper page holds only data bits 6:0 and reads back with bit 7 zero. Reads at offsets 0, 4, 5 and 6 return 0.
- R3: Writes at offsets 0, 4, 5 and 6 change no page register.
- R4: `mem_addr` is {upper page[6:0], lower page[7:0], low 16 address bits} of the selected channel.
- R5: With mode bit 5 = 0 (upward), the low 16 address bits equal `cur_addr` + count, modulo 2^16.
- R6: With mode bit 5 = 1 (downward), the low 16 address bits equal `cur_addr` − count − unit, modulo 2^16.
- R7: A strobe advances only the selected channel's count, by 1 when `word_mode`=0 and by 2 when `word_mode`=1. The new count is visible after the clock edge that samples the strobe.
- R8: The total length is (`base_count`+1) shifted left by `word_mode`. In the cycle after the strobe that brings the count to the total, `tc_pulse` is high for exactly one cycle and `tc_chan` gives that channel.
- R9: For a channel whose count has reached the total without autoinitialisation, further strobes leave the count unchanged and raise no pulse.
- R10: If mode bit 4 (autoinitialise) was set when the terminal strobe was sampled, the count is 0 one cycle after it reached the total.
- R11: A `restart` pulse clears the selected channel's count on the next edge.
- R12: `autoinit` reports mode bit 4 and `xfer_type` reports mode bits 3:2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pg_wr_en | input | 1 | Page register write strobe |
| pg_wr_hi | input | 1 | Write targets upper page (1) or lower page (0) |
| pg_wr_off | input | 3 | Page register write offset |
| pg_wr_data | input | 8 | Page register write data |
| pg_rd_hi | input | 1 | Read selects upper page (1) or lower page (0) |
| pg_rd_off | input | 3 | Page register read offset |
| pg_rd_data | output | 8 | Page register read data |
| ch_sel | input | 2 | Active channel |
| mode_bits | input | 4 | Mode bits 5:2 of the active channel |
| word_mode | input | 1 | 1 = two-byte units |
| base_count | input | 16 | Programmed count of the active channel |
| cur_addr | input | 16 | Current address of the active channel |
| xfer_strobe | input | 1 | One unit transferred this cycle |
| restart | input | 1 | Clear the active channel's count |
| mem_addr | output | 31 | Physical address of the next unit |
| xfer_count | output | 18 | Transferred count of the active channel |
| tc_pulse | output | 1 | Terminal count reached |
| tc_chan | output | 2 | Channel that reached terminal count |
| autoinit | output | 1 | Autoinitialise mode decoded |
| xfer_type | output | 2 | Transfer type decoded |

## Verification
The active channel's count is always visible on `xfer_count`, and `mem_addr` is built from it. A count register that is stuck, steps by the wrong amount or is disturbed by another channel's strobe therefore shows up on the ports in the very next cycle. A wrong address offset or page lane appears immediately, as soon as the channel is selected. A broken terminal comparison shows up as a missing pulse, an early pulse or a count that moves past the total, all within one cycle of the final strobe. A missing reload under autoinitialisation shows up one cycle after that.

// File: rtl/dma_ag_pkg.sv
// Package: shared widths, types and the page-offset decoder for the DMA address generator.
// Assumes four channels whose page registers sit at a fixed sparse offset map.
package dma_ag_pkg;

    localparam int NUM_CH  = 4;
    localparam int CH_W    = 2;
    localparam int OFF_W   = 3;

    typedef struct packed {
        logic            valid;
        logic [CH_W-1:0] chan;
    } pg_slot_t;

    // Map a page port offset to a channel; unused offsets are invalid.
    function automatic pg_slot_t decode_pg_off(input logic [OFF_W-1:0] off);
        pg_slot_t s;
        s.valid = 1'b1;
        s.chan  = '0;
        case (off)
            3'd7:    s.chan = 2'd0;
            3'd3:    s.chan = 2'd1;
            3'd1:    s.chan = 2'd2;
            3'd2:    s.chan = 2'd3;
            default: s.valid = 1'b0;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/dma_ag_page_regs.sv
// Page register bank: one lower and one upper page per channel.
// Assumes writes are single-cycle strobes; reads are combinational.
// Offsets outside the channel map are neither written nor readable (read 0).
module dma_ag_page_regs
    import dma_ag_pkg::*;
#(
    parameter int PAGE_W  = 8,
    parameter int HPAGE_W = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               wr_hi,
    input  logic [OFF_W-1:0]   wr_off,
    input  logic [PAGE_W-1:0]  wr_data,
    input  logic               rd_hi,
    input  logic [OFF_W-1:0]   rd_off,
    output logic [PAGE_W-1:0]  rd_data,
    input  logic [CH_W-1:0]    sel_ch,
    output logic [PAGE_W-1:0]  sel_lo,
    output logic [HPAGE_W-1:0] sel_hi
);

    logic [PAGE_W-1:0]  lo_q [NUM_CH];
    logic [HPAGE_W-1:0] hi_q [NUM_CH];
    pg_slot_t           wr_slot;
    pg_slot_t           rd_slot;

    // Decode both offsets.
    always_comb begin
        wr_slot = decode_pg_off(wr_off);
        rd_slot = decode_pg_off(rd_off);
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        // Per-channel storage, written only on a valid decode to this channel.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lo_q[c] <= '0;
                hi_q[c] <= '0;
            end else if (wr_en && wr_slot.valid && wr_slot.chan == CH_W'(c)) begin
                if (wr_hi) hi_q[c] <= wr_data[HPAGE_W-1:0];
                else       lo_q[c] <= wr_data;
            end
        end
    end

    // Read mux; invalid offsets return zero.
    always_comb begin
        rd_data = '0;
        if (rd_slot.valid) begin
            if (rd_hi) rd_data = PAGE_W'(hi_q[rd_slot.chan]);
            else       rd_data = lo_q[rd_slot.chan];
        end
    end

    // Pages of the active channel for address forming.
    always_comb begin
        sel_lo = lo_q[sel_ch];
        sel_hi = hi_q[sel_ch];
    end

endmodule

// File: rtl/dma_ag_chan_count.sv
// Transferred-count register of one channel.
// Assumes unit/total/autoinit describe the channel only while it is selected.
// Priority: restart, then autoinit reload, then strobe advance.
module dma_ag_chan_count #(
    parameter int CNT_W = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel,
    input  logic             strobe,
    input  logic             restart,
    input  logic             auto_en,
    input  logic [1:0]       unit,
    input  logic [CNT_W-1:0] total,
    output logic [CNT_W-1:0] count,
    output logic             tc_hit
);

    logic [CNT_W-1:0] cnt_q;
    logic             reload_q;
    logic [CNT_W-1:0] cnt_next;
    logic             at_end;
    logic             step;

    // Advance candidate and end detection.
    always_comb begin
        cnt_next = cnt_q + CNT_W'(unit);
        at_end   = (cnt_q >= total);
        step     = sel && strobe && !restart && !reload_q && !at_end;
        tc_hit   = step && (cnt_next >= total);
    end

    // Count register with reload bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            reload_q <= 1'b0;
        end else if (sel && restart) begin
            cnt_q    <= '0;
            reload_q <= 1'b0;
        end else if (reload_q) begin
            cnt_q    <= '0;
            reload_q <= 1'b0;
        end else if (step) begin
            cnt_q    <= cnt_next;
            reload_q <= tc_hit && auto_en;
        end
    end

    assign count = cnt_q;

endmodule

// File: rtl/dma_ag_addr_form.sv
// Builds the physical address from the pages and the offset within the block.
// Upward: base + count. Downward: base - count - unit. Low part wraps at 16 bits.
module dma_ag_addr_form #(
    parameter int ADDR_W  = 16,
    parameter int PAGE_W  = 8,
    parameter int HPAGE_W = 7,
    parameter int CNT_W   = 18,
    localparam int OUT_W  = ADDR_W + PAGE_W + HPAGE_W
) (
    input  logic [ADDR_W-1:0]  base_addr,
    input  logic [CNT_W-1:0]   count,
    input  logic [1:0]         unit,
    input  logic               down,
    input  logic [PAGE_W-1:0]  page_lo,
    input  logic [HPAGE_W-1:0] page_hi,
    output logic [OUT_W-1:0]   addr
);

    logic [ADDR_W-1:0] offs;
    logic [ADDR_W-1:0] low;

    // Offset arithmetic in the address width.
    always_comb begin
        offs = count[ADDR_W-1:0];
        if (down) low = base_addr - offs - ADDR_W'(unit);
        else      low = base_addr + offs;
        addr = {page_hi, page_lo, low};
    end

endmodule

// File: rtl/dma_addr_gen.sv
// DMA transfer address generator top.
// Assumes one active channel per cycle chosen by ch_sel; mode/base/address
// inputs describe that channel. Synchronous active-low reset.
module dma_addr_gen
    import dma_ag_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int PAGE_W  = 8,
    parameter int HPAGE_W = 7,
    localparam int CNT_W  = ADDR_W + 2,
    localparam int OUT_W  = ADDR_W + PAGE_W + HPAGE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pg_wr_en,
    input  logic              pg_wr_hi,
    input  logic [2:0]        pg_wr_off,
    input  logic [PAGE_W-1:0] pg_wr_data,
    input  logic              pg_rd_hi,
    input  logic [2:0]        pg_rd_off,
    output logic [PAGE_W-1:0] pg_rd_data,
    input  logic [1:0]        ch_sel,
    input  logic [5:2]        mode_bits,
    input  logic              word_mode,
    input  logic [ADDR_W-1:0] base_count,
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic              xfer_strobe,
    input  logic              restart,
    output logic [OUT_W-1:0]  mem_addr,
    output logic [CNT_W-1:0]  xfer_count,
    output logic              tc_pulse,
    output logic [1:0]        tc_chan,
    output logic              autoinit,
    output logic [1:0]        xfer_type
);

    logic [PAGE_W-1:0]  sel_lo;
    logic [HPAGE_W-1:0] sel_hi;
    logic [CNT_W-1:0]   total;
    logic [1:0]         unit;
    logic [CNT_W-1:0]   cnt   [NUM_CH];
    logic [NUM_CH-1:0]  hit;
    logic               tc_q;
    logic [1:0]         tc_ch_q;

    // Length and unit from the word shift.
    always_comb begin
        unit  = word_mode ? 2'd2 : 2'd1;
        total = (CNT_W'(base_count) + CNT_W'(1)) << word_mode;
    end

    // Mode field decode.
    always_comb begin
        autoinit  = mode_bits[4];
        xfer_type = mode_bits[3:2];
    end

    dma_ag_page_regs #(.PAGE_W(PAGE_W), .HPAGE_W(HPAGE_W)) u_pages (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (pg_wr_en),
        .wr_hi   (pg_wr_hi),
        .wr_off  (pg_wr_off),
        .wr_data (pg_wr_data),
        .rd_hi   (pg_rd_hi),
        .rd_off  (pg_rd_off),
        .rd_data (pg_rd_data),
        .sel_ch  (ch_sel),
        .sel_lo  (sel_lo),
        .sel_hi  (sel_hi)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_cnt
        dma_ag_chan_count #(.CNT_W(CNT_W)) u_cnt (
            .clk     (clk),
            .rst_n   (rst_n),
            .sel     (ch_sel == 2'(c)),
            .strobe  (xfer_strobe),
            .restart (restart),
            .auto_en (mode_bits[4]),
            .unit    (unit),
            .total   (total),
            .count   (cnt[c]),
            .tc_hit  (hit[c])
        );
    end

    // Active channel's count.
    assign xfer_count = cnt[ch_sel];

    dma_ag_addr_form #(
        .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .HPAGE_W(HPAGE_W), .CNT_W(CNT_W)
    ) u_addr (
        .base_addr (cur_addr),
        .count     (xfer_count),
        .unit      (unit),
        .down      (mode_bits[5]),
        .page_lo   (sel_lo),
        .page_hi   (sel_hi),
        .addr      (mem_addr)
    );

    // Register the terminal-count pulse and its channel tag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tc_q    <= 1'b0;
            tc_ch_q <= '0;
        end else begin
            tc_q    <= |hit;
            tc_ch_q <= ch_sel;
        end
    end

    assign tc_pulse = tc_q;
    assign tc_chan  = tc_ch_q;

endmodule

// File: rtl/dma_addr_gen_chk.sv
// Checker for dma_addr_gen; observes ports only.
module dma_addr_gen_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [2:0]  pg_rd_off,
    input logic [7:0]  pg_rd_data,
    input logic [1:0]  ch_sel,
    input logic [5:2]  mode_bits,
    input logic        word_mode,
    input logic [15:0] base_count,
    input logic [15:0] cur_addr,
    input logic        xfer_strobe,
    input logic        restart,
    input logic [30:0] mem_addr,
    input logic [17:0] xfer_count,
    input logic        tc_pulse,
    input logic [1:0]  tc_chan
);

    logic [17:0] tot_c;
    logic [17:0] unit_c;
    assign tot_c  = (18'(base_count) + 18'd1) << word_mode;
    assign unit_c = word_mode ? 18'd2 : 18'd1;

    p_tc_after_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_pulse && $past(rst_n)) |-> $past(xfer_strobe));

    p_tc_chan_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_pulse && $past(rst_n)) |-> tc_chan == $past(ch_sel));

    p_count_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ch_sel == $past(ch_sel) && $past(xfer_strobe) &&
         !$past(restart) && $past(xfer_count) < $past(tot_c))
        |-> xfer_count == $past(xfer_count) + $past(unit_c));

    p_addr_up_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_bits[5] |-> mem_addr[15:0] == cur_addr + xfer_count[15:0]);

    p_addr_down_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mode_bits[5] |-> mem_addr[15:0] == cur_addr - xfer_count[15:0] - unit_c[15:0]);

    p_bad_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pg_rd_off == 3'd0 || pg_rd_off == 3'd4 || pg_rd_off == 3'd5 || pg_rd_off == 3'd6)
        |-> pg_rd_data == 8'd0);

    p_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(restart) && ch_sel == $past(ch_sel)) |-> xfer_count == 18'd0);

endmodule

bind dma_addr_gen dma_addr_gen_chk u_chk (
    .clk(clk), .rst_n(rst_n), .pg_rd_off(pg_rd_off), .pg_rd_data(pg_rd_data),
    .ch_sel(ch_sel), .mode_bits(mode_bits), .word_mode(word_mode),
    .base_count(base_count), .cur_addr(cur_addr), .xfer_strobe(xfer_strobe),
    .restart(restart), .mem_addr(mem_addr), .xfer_count(xfer_count),
    .tc_pulse(tc_pulse), .tc_chan(tc_chan)
);

// File: tb/dma_addr_gen_test.sv
`timescale 1ns/1ps
module dma_addr_gen_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pg_wr_en = 0, pg_wr_hi = 0;
    logic [2:0]  pg_wr_off = 0;
    logic [7:0]  pg_wr_data = 0;
    logic        pg_rd_hi = 0;
    logic [2:0]  pg_rd_off = 0;
    logic [7:0]  pg_rd_data;
    logic [1:0]  ch_sel = 0;
    logic [5:2]  mode_bits = 0;
    logic        word_mode = 0;
    logic [15:0] base_count = 0, cur_addr = 0;
    logic        xfer_strobe = 0, restart = 0;
    logic [30:0] mem_addr;
    logic [17:0] xfer_count;
    logic        tc_pulse;
    logic [1:0]  tc_chan;
    logic        autoinit;
    logic [1:0]  xfer_type;

    int checks = 0;
    int errors = 0;
    logic [7:0]  exp_lo [4];
    logic [6:0]  exp_hi [4];
    logic [17:0] exp_cnt [4];

    always #2 clk = ~clk;

    dma_addr_gen uut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Channel of a page offset per the offset map, -1 if unused.
    function automatic int off_ch(input int off);
        case (off)
            7: return 0;
            3: return 1;
            1: return 2;
            2: return 3;
            default: return -1;
        endcase
    endfunction

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic pg_write(input logic hi, input int off, input logic [7:0] d);
        pg_wr_en = 1; pg_wr_hi = hi; pg_wr_off = 3'(off); pg_wr_data = d;
        tick();
        pg_wr_en = 0;
    endtask

    task automatic check_pages(input string req);
        for (int off = 0; off < 8; off++) begin
            for (int h = 0; h < 2; h++) begin
                int c;
                c = off_ch(off);
                pg_rd_off = 3'(off); pg_rd_hi = h[0]; #1;
                if (c < 0) chk(req, 32'(pg_rd_data), 0);
                else if (h == 1) chk(req, 32'(pg_rd_data), {25'd0, exp_hi[c]});
                else chk(req, 32'(pg_rd_data), {24'd0, exp_lo[c]});
            end
        end
    endtask

    task automatic check_addr(input int c, input logic dn, input logic wm);
        logic [15:0] low;
        logic [15:0] u;
        u = wm ? 16'd2 : 16'd1;
        low = dn ? cur_addr - exp_cnt[c][15:0] - u : cur_addr + exp_cnt[c][15:0];
        #1;
        chk(dn ? "R6 down addr" : "R5 up addr", {1'b0, mem_addr}, {1'b0, exp_hi[c], exp_lo[c], low});
    endtask

    initial begin : wd
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int c = 0; c < 4; c++) begin exp_lo[c] = 0; exp_hi[c] = 0; exp_cnt[c] = 0; end
        repeat (3) tick();
        // R1 reset state
        chk("R1 tc", {31'd0, tc_pulse}, 0);
        for (int c = 0; c < 4; c++) begin
            ch_sel = 2'(c); #1;
            chk("R1 count", 32'(xfer_count), 0);
        end
        check_pages("R1 pages");
        rst_n = 1;
        tick();

        // R2 page map: valid offsets first, then invalid offsets (R3 ignored)
        for (int off = 0; off < 8; off++) begin
            int c;
            c = off_ch(off);
            if (c >= 0) begin
                pg_write(0, off, 8'h30 + 8'(off * 17));
                pg_write(1, off, 8'hC0 | 8'(off * 9));
                exp_lo[c] = 8'h30 + 8'(off * 17);
                exp_hi[c] = 7'((8'hC0 | 8'(off * 9)) & 8'h7F);
            end
        end
        check_pages("R2 map");
        for (int off = 0; off < 8; off++)
            if (off_ch(off) < 0) begin pg_write(0, off, 8'hA5); pg_write(1, off, 8'h5A); end
        check_pages("R3 invalid write");

        // R12 mode decode
        for (int m = 0; m < 16; m++) begin
            mode_bits = 4'(m); #1;
            chk("R12 autoinit", {31'd0, autoinit}, {31'd0, m[2]});
            chk("R12 type", {30'd0, xfer_type}, {30'd0, m[1:0]});
        end

        // R4..R11 count sweep
        cur_addr = 16'h0003;
        for (int c = 0; c < 4; c++)
        for (int wm = 0; wm < 2; wm++)
        for (int b = 0; b < 4; b++)
        for (int au = 0; au < 2; au++)
        for (int dn = 0; dn < 2; dn++) begin
            int n;
            ch_sel = 2'(c); word_mode = wm[0]; base_count = 16'(b);
            mode_bits = {dn[0], au[0], 2'b01};
            cur_addr = cur_addr + 16'h1F31;
            restart = 1; tick(); restart = 0;
            exp_cnt[c] = 0;
            chk("R11 restart", 32'(xfer_count), 0);
            n = b + 1;
            for (int k = 1; k <= n; k++) begin
                check_addr(c, dn[0], wm[0]);
                xfer_strobe = 1; tick(); xfer_strobe = 0;
                exp_cnt[c] = 18'(k * (wm + 1));
                chk("R7 step", 32'(xfer_count), 32'(exp_cnt[c]));
                chk("R8 tc", {31'd0, tc_pulse}, (k == n) ? 1 : 0);
                if (k == n) chk("R8 tc chan", {30'd0, tc_chan}, 32'(c));
            end
            if (au == 1) begin
                tick();
                exp_cnt[c] = 0;
                chk("R10 reload", 32'(xfer_count), 0);
                chk("R8 single pulse", {31'd0, tc_pulse}, 0);
            end else begin
                xfer_strobe = 1; tick(); xfer_strobe = 0;
                chk("R9 hold", 32'(xfer_count), 32'(exp_cnt[c]));
                tick();
                chk("R9 no pulse", {31'd0, tc_pulse}, 0);
            end
            check_addr(c, dn[0], wm[0]);
            // R7 other channels untouched
            for (int o = 0; o < 4; o++) begin
                ch_sel = 2'(o); #1;
                chk("R7 isolation", 32'(xfer_count), 32'(exp_cnt[o]));
            end
            ch_sel = 2'(c);
        end

        // R4 address lanes for every channel with a nonzero count
        mode_bits = 4'b0000; word_mode = 0; base_count = 16'd10;
        for (int c = 0; c < 4; c++) begin
            ch_sel = 2'(c); cur_addr = 16'hFFFE - 16'(c);
            restart = 1; tick(); restart = 0; exp_cnt[c] = 0;
            xfer_strobe = 1; tick(); tick(); tick(); xfer_strobe = 0;
            exp_cnt[c] = 3;
            #1;
            chk("R4 lanes", {1'b0, mem_addr}, {1'b0, exp_hi[c], exp_lo[c], cur_addr + 16'd3});
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule